// File: doc/BRIEF.md
# PWM Tone Sound Generator

This block drives a buzzer. An 8-bit pulse-width carrier sets the loudness. A square tone produced by an 8-bit reload divider gates that carrier, and the divider advances once per completed carrier period. The tone frequency therefore follows from the carrier frequency: one tone period spans `2 * (reload + 1)` carrier periods. The block has two outputs. One carries the gated carrier, which is the sound. The other carries the bare tone level, for a driver that wants it.

The carrier period is 256 prescaled ticks. A two-bit select divides the clock by 1, 2, 4 or 8 to make each tick, so one carrier period is 256, 512, 1024 or 2048 clocks. An optional tone-period count raises a one-cycle interrupt after a programmed number of full tone periods. The same count can also silence the block on its own.

Control is a small state machine with three states:
- `S_IDLE`: silent, counters held.
- `S_PLAY`: sounding.
- `S_HOLD`: silenced automatically after the count ran out.

It has five transitions:
- `S_IDLE`→`S_PLAY` when enable is high. This restarts every counter.
- `S_PLAY`→`S_IDLE` when enable goes low.
- `S_PLAY`→`S_HOLD` when the count expires with auto-stop set.
- `S_HOLD`→`S_IDLE` when enable goes low.
- Every other case stays in the current state.

Top module: `tone_buzzer`

## Requirements
- R1: While reset is asserted, and while enable is low, `sound_o`, `tone_o` and `done_irq_o` are all low.
- R2: Select value s (0..3) makes one carrier period 256·2^s clocks, and the carrier count advances every 2^s clocks. In time, 0 gives /256, 1 gives /512, 2 gives /1024 and 3 gives /2048.
- R3: Within each carrier period the carrier is high for the first `duty` counts of 256. A duty of 0 keeps the carrier low for the whole period.
- R4: `tone_o` is high from the start. It toggles after every (reload+1) completed carrier periods, so the tone frequency is the carrier frequency / (2·(reload+1)). The reload value is read at start and again at each underflow of the divider.
- R5: `sound_o` equals the carrier AND the tone level.
- R6: Duty and prescale select are sampled at start and at each carrier-period boundary only. A change made inside a period takes effect from the next period.
- R7: Clearing enable forces both outputs low from the following cycle. Setting enable again restarts everything from count zero with the tone high.
- R8: With a nonzero cycle count N, `done_irq_o` pulses high for exactly one cycle when the Nth full tone period ends, that is 2·N·(reload+1) carrier periods after start. With N = 0 it never pulses.
- R9: With auto-stop set, both outputs stay low from that pulse onward until enable is cleared and set again. Without auto-stop, sound continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable_i | input | 1 | Play request; low silences and restarts |
| presc_sel_i | input | 2 | Carrier clock divide select (2^s) |
| duty_i | input | 8 | Carrier high count per 256 |
| reload_i | input | 8 | Tone divider reload value |
| cycles_i | input | 8 | Number of tone periods before the interrupt; 0 disables |
| auto_stop_i | input | 1 | Silence automatically when the count expires |
| sound_o | output | 1 | Carrier gated by tone |
| tone_o | output | 1 | Tone level |
| done_irq_o | output | 1 | One-cycle pulse at the end of the counted tone periods |

## Verification
A corrupt carrier count or prescaler shows at once on `sound_o`: the high/low split inside the next carrier period is wrong. A bad tone divider shows at `tone_o` at the next carrier boundary where a toggle is due, or where a toggle is wrongly missing. A wrong tone-period count or a wrong state moves the interrupt pulse and the silence point by whole tone periods, so it appears only at the expected finish time. The bench therefore compares every output on every cycle against a closed-form timing model, through that finish time and beyond it.

// File: rtl/tone_pkg.sv
`timescale 1ns/1ps
package tone_pkg;
    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_PLAY = 2'd1,
        S_HOLD = 2'd2
    } tone_state_e;
endpackage

// File: rtl/tone_pwm.sv
`timescale 1ns/1ps
// Prescaler, carrier counter and duty compare.
module tone_pwm #(
    parameter int SEL_W = 2,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    input  logic [CNT_W-1:0] duty,
    output logic             pwm_o,
    output logic             period_end_o
);
    localparam int PRE_W = (1 << SEL_W) - 1;

    logic [PRE_W-1:0] presc_q;
    logic [PRE_W-1:0] mask;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] duty_q;
    logic [SEL_W-1:0] sel_q;
    logic             tick;

    always_comb begin
        mask         = PRE_W'((1 << sel_q) - 1);
        tick         = (presc_q == mask);
        period_end_o = run && tick && (cnt_q == {CNT_W{1'b1}});
        pwm_o        = (cnt_q < duty_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            presc_q <= '0;
            cnt_q   <= '0;
            duty_q  <= '0;
            sel_q   <= '0;
        end else if (restart) begin
            presc_q <= '0;
            cnt_q   <= '0;
            duty_q  <= duty;
            sel_q   <= sel;
        end else if (run) begin
            if (tick) begin
                presc_q <= '0;
                cnt_q   <= cnt_q + 1'b1;
                if (cnt_q == {CNT_W{1'b1}}) begin
                    duty_q <= duty;
                    sel_q  <= sel;
                end
            end else begin
                presc_q <= presc_q + 1'b1;
            end
        end
    end

    // R3: a zero latched duty never lets the carrier high
    a_r3_zero_duty_low: assert property (@(posedge clk) disable iff (!rst_n)
        (duty_q == '0) |-> !pwm_o);

    // R6: latched duty only moves at a period boundary or a restart
    a_r6_duty_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && !period_end_o) |=> $stable(duty_q));
endmodule

// File: rtl/tone_div.sv
`timescale 1ns/1ps
// Tone reload divider, clocked by carrier-period boundaries.
module tone_div #(
    parameter int RLD_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             period_end,
    input  logic [RLD_W-1:0] reload,
    output logic             tone_o,
    output logic             wrap_o
);
    logic [RLD_W-1:0] tcnt_q;
    logic             tone_q;

    always_comb begin
        tone_o = tone_q;
        wrap_o = period_end && (tcnt_q == '0) && !tone_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tcnt_q <= '0;
            tone_q <= 1'b0;
        end else if (restart) begin
            tcnt_q <= reload;
            tone_q <= 1'b1;
        end else if (period_end) begin
            if (tcnt_q == '0) begin
                tone_q <= ~tone_q;
                tcnt_q <= reload;
            end else begin
                tcnt_q <= tcnt_q - 1'b1;
            end
        end
    end

    // R4: the tone level changes only at a carrier boundary or restart
    a_r4_tone_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && !period_end) |=> $stable(tone_q));
endmodule

// File: rtl/tone_buzzer.sv
`timescale 1ns/1ps
module tone_buzzer #(
    parameter int SEL_W = 2,
    parameter int CNT_W = 8,
    parameter int RLD_W = 8,
    parameter int CYC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable_i,
    input  logic [SEL_W-1:0] presc_sel_i,
    input  logic [CNT_W-1:0] duty_i,
    input  logic [RLD_W-1:0] reload_i,
    input  logic [CYC_W-1:0] cycles_i,
    input  logic             auto_stop_i,
    output logic             sound_o,
    output logic             tone_o,
    output logic             done_irq_o
);
    import tone_pkg::*;

    tone_state_e      state_q, state_d;
    logic [CYC_W-1:0] cyc_q;
    logic             irq_q;
    logic             run, restart;
    logic             pwm, tone, period_end, wrap;
    logic             last_cycle;

    always_comb begin
        run        = (state_q == S_PLAY);
        restart    = (state_q == S_IDLE) && enable_i;
        last_cycle = run && wrap && (cyc_q == CYC_W'(1));
    end

    tone_pwm #(.SEL_W(SEL_W), .CNT_W(CNT_W)) u_pwm (
        .clk          (clk),
        .rst_n        (rst_n),
        .restart      (restart),
        .run          (run),
        .sel          (presc_sel_i),
        .duty         (duty_i),
        .pwm_o        (pwm),
        .period_end_o (period_end)
    );

    tone_div #(.RLD_W(RLD_W)) u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (restart),
        .period_end (period_end),
        .reload     (reload_i),
        .tone_o     (tone),
        .wrap_o     (wrap)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (enable_i) state_d = S_PLAY;
            S_PLAY: begin
                if (!enable_i)                      state_d = S_IDLE;
                else if (last_cycle && auto_stop_i) state_d = S_HOLD;
            end
            S_HOLD: if (!enable_i) state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // state register, tone-period count and interrupt pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            cyc_q   <= '0;
            irq_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            irq_q   <= last_cycle && enable_i;
            if (restart)
                cyc_q <= cycles_i;
            else if (run && wrap && cyc_q != '0)
                cyc_q <= cyc_q - 1'b1;
        end
    end

    // outputs
    always_comb begin
        sound_o    = run && pwm && tone;
        tone_o     = run && tone;
        done_irq_o = irq_q;
    end

    // R8: the interrupt is a single-cycle pulse
    a_r8_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq_o |=> !done_irq_o);

    // R7: a low enable always lands the machine in idle
    a_r7_disable_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> (state_q == S_IDLE));

    // R9: after an automatic stop the block is silent on the next cycle
    a_r9_hold_after_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (done_irq_o && auto_stop_i && $stable(enable_i) && enable_i) |-> (state_q == S_HOLD));
endmodule

// File: tb/test_tone_buzzer.sv
`timescale 1ns/1ps
module test_tone_buzzer;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       enable_i;
    logic [1:0] presc_sel_i;
    logic [7:0] duty_i;
    logic [7:0] reload_i;
    logic [7:0] cycles_i;
    logic       auto_stop_i;
    logic       sound_o, tone_o, done_irq_o;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  finished = 0;

    always #2.5 clk = ~clk;

    tone_buzzer i_tone_buzzer (
        .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .presc_sel_i(presc_sel_i),
        .duty_i(duty_i), .reload_i(reload_i), .cycles_i(cycles_i),
        .auto_stop_i(auto_stop_i), .sound_o(sound_o), .tone_o(tone_o),
        .done_irq_o(done_irq_o)
    );

    task automatic check(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
        end
    endtask

    // expected {sound, tone, irq} t cycles after the starting edge
    function automatic logic [2:0] model(int t, int sel, int duty, int r, int n, bit auto_s);
        int  d     = 1 << sel;
        int  plen  = 256 * d;
        int  p     = t / plen;
        int  pos   = (t % plen) / d;
        int  fin   = n * 2 * (r + 1) * plen;
        bit  pw    = (pos < duty);
        bit  tn    = ((p / (r + 1)) % 2) == 0;
        bit  irq   = (n != 0) && (t == fin);
        if (n != 0 && auto_s && t >= fin) begin
            pw = 1'b0;
            tn = 1'b0;
        end
        return {pw & tn, tn, irq};
    endfunction

    task automatic start(input int sel, input int duty, input int r, input int n, input bit auto_s);
        @(negedge clk);
        enable_i = 1'b0;
        @(negedge clk);
        presc_sel_i = 2'(sel);
        duty_i      = 8'(duty);
        reload_i    = 8'(r);
        cycles_i    = 8'(n);
        auto_stop_i = auto_s;
        enable_i    = 1'b1;
    endtask

    task automatic play(input string tag, input int sel, input int duty, input int r,
                        input int n, input bit auto_s, input int len);
        start(sel, duty, r, n, auto_s);
        for (int t = 0; t < len; t++) begin
            logic [2:0] e;
            int         fin;
            @(negedge clk);
            e   = model(t, sel, duty, r, n, auto_s);
            fin = n * 2 * (r + 1) * 256 * (1 << sel);
            check((n != 0 && auto_s && t >= fin) ? "R9" : tag, "sound", sound_o, e[2]);
            check("R4", "tone", tone_o, e[1]);
            check("R8", "irq", done_irq_o, e[0]);
        end
    endtask

    initial begin
        rst_n = 1'b0; enable_i = 1'b0; presc_sel_i = '0; duty_i = '0;
        reload_i = '0; cycles_i = '0; auto_stop_i = 1'b0;
        repeat (3) @(negedge clk);
        // R1: outputs in reset
        check("R1", "sound", sound_o, 1'b0);
        check("R1", "tone", tone_o, 1'b0);
        check("R1", "irq", done_irq_o, 1'b0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R1", "sound idle", sound_o, 1'b0);
        check("R1", "tone idle", tone_o, 1'b0);

        // R3: zero duty stays low
        play("R3", 0, 0, 0, 0, 1'b0, 600);
        // R2 R9: slow select, full duty, auto stop after one tone period
        play("R2", 2, 255, 0, 1, 1'b1, 2 * 1024 + 12);
        // R2: slowest select
        play("R2", 3, 37, 0, 0, 1'b0, 4200);
        // R8: pulse without stopping
        play("R8", 0, 90, 1, 1, 1'b0, 1024 + 600);

        // R6: duty changed inside period 0 applies from period 1
        start(0, 200, 3, 0, 1'b0);
        for (int t = 0; t < 1024; t++) begin
            logic [2:0] e;
            @(negedge clk);
            e = model(t, 0, (t < 256) ? 200 : 50, 3, 0, 1'b0);
            check("R6", "sound", sound_o, e[2]);
            if (t == 100) duty_i = 8'd50;
        end

        // R7: clearing enable mid-play, then restart from zero
        start(1, 128, 0, 0, 1'b0);
        for (int t = 0; t < 300; t++) begin
            logic [2:0] e;
            @(negedge clk);
            e = model(t, 1, 128, 0, 0, 1'b0);
            check("R5", "sound", sound_o, e[2]);
        end
        enable_i = 1'b0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R7", "sound off", sound_o, 1'b0);
            check("R7", "tone off", tone_o, 1'b0);
        end
        enable_i = 1'b1;
        for (int t = 0; t < 600; t++) begin
            logic [2:0] e;
            @(negedge clk);
            e = model(t, 1, 128, 0, 0, 1'b0);
            check("R7", "sound restart", sound_o, e[2]);
            check("R7", "tone restart", tone_o, e[1]);
        end

        // random trials with a fixed seed
        void'($urandom(32'h5eed1));
        for (int k = 0; k < 6; k++) begin
            int sel = $urandom % 2;
            int dty = $urandom % 256;
            int r   = $urandom % 3;
            int n   = 1 + ($urandom % 2);
            play("R5", sel, dty, r, n, 1'b1, n * 2 * (r + 1) * 256 * (1 << sel) + 16);
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule